// File: doc/BRIEF.md
# Cache memory type range resolver

This block answers, in the same cycle, which cacheability type applies to a physical address. It holds a small configuration store: a control word with a global enable, a fixed-range enable and a default type; a capability word with a fixed-range capability bit and a count of variable ranges; eleven fixed-range words of eight type fields each; and a parameterised number of variable ranges, each a base word and a mask word. A single indexed write port with a strobe programs all of it. The lookup output depends only on the address input and the stored configuration.

The first megabyte is split into eleven fixed regions of uneven size: one of 512 KiB, two of 128 KiB and eight of 32 KiB. Each region is cut into eight equal slices, so a slice is 64 KiB, 16 KiB or 4 KiB depending on the region. When fixed decoding is not in force, or the address lies above the first megabyte, the variable ranges are compared under their masks. Overlapping matches are resolved by precedence. When nothing matches, the default type is returned.

Top module: `mtr_resolver`

## Requirements
- R1: While the global enable (control word bit 11) is 0, `lkp_type` is the uncached code 0 for every address and every other setting.
- R2: With global enable, fixed-range capability (capability word bit 8) and fixed-range enable (control word bit 10) all set, an address below 0x100000 returns a fixed slice type. Regions 0..10 end at 0x7FFFF, 0x9FFFF, 0xBFFFF, then every 0x8000 up to 0xFFFFF. The slice index is the offset from the region base shifted right by 16 in region 0, by 14 in regions 1 and 2, and by 12 in regions 3 to 10. Slice j of a region is bits [8j+2:8j] of that region's word.
- R3: If either the capability bit or the fixed enable is 0, the fixed words are not consulted, and addresses below 0x100000 resolve through the variable ranges or the default.
- R4: Variable range i matches when its mask word bit 11 is 1 and (address AND mask) equals (base AND mask) over address bits [ADDR_W-1:12]. Bits [11:0] of base and mask take no part in the match. The range type is base word bits [2:0].
- R5: Among matching variable ranges, uncached (0) wins over every other type. Write-through (4) wins over all remaining types. Otherwise the type of the highest-indexed matching range is returned.
- R6: Only variable ranges with index below the capability count (capability word bits [7:0]) are consulted. A count above NUM_VAR consults all ranges.
- R7: When no fixed slice and no variable range applies, the default type (control word bits [2:0]) is returned. A fixed slice that applies takes precedence over any variable match.
- R8: A write with `cfg_we` high updates the register selected by `cfg_idx` at the clock edge: 0 is the control word, 1 is the capability word, 2..12 are fixed regions 0..10, 32+2i is the base of range i and 33+2i is its mask. Writes to other indexes change nothing. Reset clears every register, so the type after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Register index of the write |
| cfg_wdata | input | 64 | Write data |
| lkp_addr | input | ADDR_W | Physical address to resolve |
| lkp_type | output | 3 | Resolved memory type (0 uncached, 4 write-through, 6 write-back) |

## Verification
The hardest situation to reach is a three- or four-way overlap of variable ranges in which the precedence rule, the valid bit and the count field each change the answer. The stimulus programs nested ranges of shrinking size, 4 MiB, 2 MiB, 1 MiB and 512 KiB, that all end at the same address, so that a single probe address sees every overlap. It then toggles one valid bit and steps the count down and up past NUM_VAR. For the fixed map, the slice contents are chosen so that adjacent slices and regions hold different codes. Probes at each region's first and last byte then expose any boundary or shift error.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    typedef logic [2:0] mtype_t;

    localparam mtype_t MT_UC = 3'd0;
    localparam mtype_t MT_WT = 3'd4;
    localparam mtype_t MT_WB = 3'd6;

    localparam int FIX_REGIONS = 11;
    localparam int FIX_FIELDS  = 8;
    localparam int PAGE_BITS   = 12;
    localparam int FIX_TOP_BIT = 20;

    localparam int IDX_CTRL = 0;
    localparam int IDX_CAP  = 1;
    localparam int IDX_FIX0 = 2;
    localparam int IDX_VAR0 = 32;

    localparam int CTRL_FE_BIT    = 10;
    localparam int CTRL_EN_BIT    = 11;
    localparam int CAP_FIX_BIT    = 8;
    localparam int MASK_VALID_BIT = 11;

endpackage

// File: rtl/mtr_regfile.sv
module mtr_regfile
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8,
    parameter int IDX_W   = 6
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          wr_en,
    input  logic [IDX_W-1:0]                              wr_idx,
    input  logic [63:0]                                   wr_data,
    output logic                                          glob_en,
    output logic                                          fix_en,
    output logic                                          fix_cap,
    output mtype_t                                        def_type,
    output logic [7:0]                                    var_cnt,
    output logic [FIX_REGIONS-1:0][FIX_FIELDS-1:0][2:0]   fix_types,
    output logic [NUM_VAR-1:0][ADDR_W-PAGE_BITS-1:0]      base_pg,
    output logic [NUM_VAR-1:0][2:0]                       base_type,
    output logic [NUM_VAR-1:0][ADDR_W-PAGE_BITS-1:0]      mask_pg,
    output logic [NUM_VAR-1:0]                            mask_vld
);

    localparam int PG_W = ADDR_W - PAGE_BITS;

    typedef struct packed {
        mtype_t                                  def_type;
        logic                                    fix_en;
        logic                                    glob_en;
        logic [7:0]                              cnt;
        logic                                    fix_cap;
        logic [FIX_REGIONS-1:0][FIX_FIELDS-1:0][2:0] fix;
        logic [NUM_VAR-1:0][PG_W-1:0]            base_pg;
        logic [NUM_VAR-1:0][2:0]                 base_type;
        logic [NUM_VAR-1:0][PG_W-1:0]            mask_pg;
        logic [NUM_VAR-1:0]                      mask_vld;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (int'(wr_idx) == IDX_CTRL) begin
                regs_d.def_type = wr_data[2:0];
                regs_d.fix_en   = wr_data[CTRL_FE_BIT];
                regs_d.glob_en  = wr_data[CTRL_EN_BIT];
            end
            if (int'(wr_idx) == IDX_CAP) begin
                regs_d.cnt     = wr_data[7:0];
                regs_d.fix_cap = wr_data[CAP_FIX_BIT];
            end
            for (int k = 0; k < FIX_REGIONS; k++) begin
                if (int'(wr_idx) == IDX_FIX0 + k) begin
                    for (int j = 0; j < FIX_FIELDS; j++) begin
                        regs_d.fix[k][j] = wr_data[8*j +: 3];
                    end
                end
            end
            for (int v = 0; v < NUM_VAR; v++) begin
                if (int'(wr_idx) == IDX_VAR0 + 2*v) begin
                    regs_d.base_pg[v]   = wr_data[ADDR_W-1:PAGE_BITS];
                    regs_d.base_type[v] = wr_data[2:0];
                end
                if (int'(wr_idx) == IDX_VAR0 + 2*v + 1) begin
                    regs_d.mask_pg[v]  = wr_data[ADDR_W-1:PAGE_BITS];
                    regs_d.mask_vld[v] = wr_data[MASK_VALID_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign glob_en   = regs_q.glob_en;
    assign fix_en    = regs_q.fix_en;
    assign fix_cap   = regs_q.fix_cap;
    assign def_type  = regs_q.def_type;
    assign var_cnt   = regs_q.cnt;
    assign fix_types = regs_q.fix;
    assign base_pg   = regs_q.base_pg;
    assign base_type = regs_q.base_type;
    assign mask_pg   = regs_q.mask_pg;
    assign mask_vld  = regs_q.mask_vld;

endmodule

// File: rtl/mtr_fixed_decode.sv
module mtr_fixed_decode
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0]                             addr,
    input  logic [FIX_REGIONS-1:0][FIX_FIELDS-1:0][2:0]   fix_types,
    output logic                                          hit,
    output mtype_t                                        ftype
);

    localparam int REG_W = $clog2(FIX_REGIONS);

    logic [REG_W-1:0] region;
    logic [2:0]       field;

    // Region 0 is 512 KiB, regions 1-2 are 128 KiB, regions 3-10 are 32 KiB.
    always_comb begin
        hit = (addr[ADDR_W-1:FIX_TOP_BIT] == '0);
        if (!addr[19]) begin
            region = '0;
            field  = addr[18:16];
        end else if (!addr[18]) begin
            region = REG_W'(1) + REG_W'(addr[17]);
            field  = addr[16:14];
        end else begin
            region = REG_W'(3) + REG_W'(addr[17:15]);
            field  = addr[14:12];
        end
        ftype = MT_UC;
        for (int k = 0; k < FIX_REGIONS; k++) begin
            if (int'(region) == k) begin
                ftype = fix_types[k][field];
            end
        end
    end

endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [ADDR_W-PAGE_BITS-1:0]                  addr_pg,
    input  logic [7:0]                                   cnt,
    input  logic [NUM_VAR-1:0][ADDR_W-PAGE_BITS-1:0]     base_pg,
    input  logic [NUM_VAR-1:0][2:0]                      base_type,
    input  logic [NUM_VAR-1:0][ADDR_W-PAGE_BITS-1:0]     mask_pg,
    input  logic [NUM_VAR-1:0]                           mask_vld,
    output logic                                         any_hit,
    output logic                                         any_uc,
    output logic                                         any_wt,
    output mtype_t                                       last_type
);

    logic [NUM_VAR-1:0] hit_vec;

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_rng
        assign hit_vec[i] = (cnt > 8'(i)) && mask_vld[i]
                          && (((addr_pg ^ base_pg[i]) & mask_pg[i]) == '0);
    end

    always_comb begin
        any_uc    = 1'b0;
        any_wt    = 1'b0;
        last_type = MT_WB;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit_vec[i]) begin
                last_type = base_type[i];
                if (base_type[i] == MT_UC) any_uc = 1'b1;
                if (base_type[i] == MT_WT) any_wt = 1'b1;
            end
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [63:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic [2:0]        lkp_type
);

    localparam int PG_W = ADDR_W - PAGE_BITS;

    logic                                        glob_en, fix_en, fix_cap;
    mtype_t                                      def_type;
    logic [7:0]                                  var_cnt;
    logic [FIX_REGIONS-1:0][FIX_FIELDS-1:0][2:0] fix_types;
    logic [NUM_VAR-1:0][PG_W-1:0]                base_pg, mask_pg;
    logic [NUM_VAR-1:0][2:0]                     base_type;
    logic [NUM_VAR-1:0]                          mask_vld;
    logic                                        fix_hit;
    mtype_t                                      fix_type;
    logic                                        var_hit, var_uc, var_wt;
    mtype_t                                      var_last;

    mtr_regfile #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_data   (cfg_wdata),
        .glob_en   (glob_en),
        .fix_en    (fix_en),
        .fix_cap   (fix_cap),
        .def_type  (def_type),
        .var_cnt   (var_cnt),
        .fix_types (fix_types),
        .base_pg   (base_pg),
        .base_type (base_type),
        .mask_pg   (mask_pg),
        .mask_vld  (mask_vld)
    );

    mtr_fixed_decode #(.ADDR_W(ADDR_W)) u_fix (
        .addr      (lkp_addr),
        .fix_types (fix_types),
        .hit       (fix_hit),
        .ftype     (fix_type)
    );

    mtr_var_match #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
        .addr_pg   (lkp_addr[ADDR_W-1:PAGE_BITS]),
        .cnt       (var_cnt),
        .base_pg   (base_pg),
        .base_type (base_type),
        .mask_pg   (mask_pg),
        .mask_vld  (mask_vld),
        .any_hit   (var_hit),
        .any_uc    (var_uc),
        .any_wt    (var_wt),
        .last_type (var_last)
    );

    always_comb begin
        if (!glob_en) begin
            lkp_type = MT_UC;
        end else if (fix_cap && fix_en && fix_hit) begin
            lkp_type = fix_type;
        end else if (var_hit) begin
            if (var_uc)      lkp_type = MT_UC;
            else if (var_wt) lkp_type = MT_WT;
            else             lkp_type = var_last;
        end else begin
            lkp_type = def_type;
        end
    end

endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [IDX_W-1:0] cfg_idx,
    input logic [63:0]      cfg_wdata,
    input logic             glob_en,
    input logic             fix_en,
    input logic             fix_cap,
    input logic [2:0]       def_type,
    input logic             fix_hit,
    input logic [2:0]       fix_type,
    input logic             var_hit,
    input logic             var_uc,
    input logic             var_wt,
    input logic [2:0]       lkp_type
);

    logic fixed_taken;
    assign fixed_taken = fix_cap && fix_en && fix_hit;

    a_r1_off_is_uc: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> lkp_type == 3'd0);

    a_r2_fixed_applies: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && fixed_taken |-> lkp_type == fix_type);

    a_r3_fixed_gated: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && !(fix_cap && fix_en) && !var_hit |-> lkp_type == def_type);

    a_r5_uc_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && !fixed_taken && var_uc |-> lkp_type == 3'd0);

    a_r5_wt_next: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && !fixed_taken && !var_uc && var_wt |-> lkp_type == 3'd4);

    a_r7_default: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && !fixed_taken && !var_hit |-> lkp_type == def_type);

    a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_idx == '0 |=> def_type == $past(cfg_wdata[2:0])
                                    && glob_en == $past(cfg_wdata[11])
                                    && fix_en == $past(cfg_wdata[10]));

endmodule

bind mtr_resolver mtr_resolver_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .glob_en   (glob_en),
    .fix_en    (fix_en),
    .fix_cap   (fix_cap),
    .def_type  (def_type),
    .fix_hit   (fix_hit),
    .fix_type  (fix_type),
    .var_hit   (var_hit),
    .var_uc    (var_uc),
    .var_wt    (var_wt),
    .lkp_type  (lkp_type)
);

// File: tb/mtr_resolver_tb_top.sv
`timescale 1ns/1ps
module mtr_resolver_tb_top;

    localparam int AW = 36;
    localparam int NV = 8;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [63:0]   cfg_wdata = '0;
    logic [AW-1:0] lkp_addr = '0;
    logic [2:0]    lkp_type;

    int    checks = 0;
    int    errors = 0;
    bit    run = 1'b0;
    string cur_req = "R8";

    // behavioural model state
    logic [63:0] m_ctrl = '0;
    logic [63:0] m_cap = '0;
    logic [63:0] m_fix [11];
    logic [63:0] m_base [NV];
    logic [63:0] m_mask [NV];

    always #2.5 clk = ~clk;

    mtr_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .IDX_W(IW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .lkp_addr  (lkp_addr),
        .lkp_type  (lkp_type)
    );

    function automatic logic [2:0] ref_type(input logic [AW-1:0] a_in);
        logic [63:0] a, lo, hi, amask;
        int n;
        bit found;
        logic [2:0] vt;
        a = 64'(a_in);
        if (!m_ctrl[11]) return 3'd0;
        if (m_cap[8] && m_ctrl[10]) begin
            for (int k = 0; k < 11; k++) begin
                int sh;
                if (k == 0)      begin lo = 0;       hi = 64'h7FFFF; end
                else if (k == 1) begin lo = 64'h80000; hi = 64'h9FFFF; end
                else if (k == 2) begin lo = 64'hA0000; hi = 64'hBFFFF; end
                else begin lo = 64'hC0000 + 64'(k-3) * 64'h8000; hi = lo + 64'h7FFF; end
                sh = (k == 0) ? 16 : ((k < 3) ? 14 : 12);
                if (a >= lo && a <= hi) begin
                    int f;
                    f = int'((a - lo) >> sh);
                    return m_fix[k][8*f +: 3];
                end
            end
        end
        n = (int'(m_cap[7:0]) < NV) ? int'(m_cap[7:0]) : NV;
        amask = ((64'd1 << AW) - 1) & ~64'hFFF;
        found = 1'b0;
        vt = 3'd6;
        for (int i = 0; i < n; i++) begin
            if (m_mask[i][11] && (((a ^ m_base[i]) & m_mask[i] & amask) == 0)) begin
                found = 1'b1;
                if (m_base[i][2:0] == 3'd0 || vt == 3'd0)      vt = 3'd0;
                else if (m_base[i][2:0] == 3'd4 || vt == 3'd4) vt = 3'd4;
                else                                           vt = m_base[i][2:0];
            end
        end
        if (found) return vt;
        return m_ctrl[2:0];
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (run) begin
            logic [2:0] e;
            e = ref_type(lkp_addr);
            checks++;
            if (lkp_type !== e) begin
                errors++;
                $display("FAIL %s model addr=%h actual=%0d expected=%0d",
                         cur_req, lkp_addr, lkp_type, e);
            end
        end
    end

    task automatic wr(input int idx, input logic [63:0] d, input string tag);
        @(posedge clk); #1;
        cur_req = tag;
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (idx == 0) m_ctrl = d;
        else if (idx == 1) m_cap = d;
        else if (idx >= 2 && idx <= 12) m_fix[idx-2] = d;
        else if (idx >= 32 && idx < 32 + 2*NV) begin
            if (idx % 2 == 0) m_base[(idx-32)/2] = d;
            else              m_mask[(idx-32)/2] = d;
        end
    endtask

    task automatic expect_t(input logic [AW-1:0] a, input logic [2:0] e, input string tag);
        @(posedge clk); #1;
        cur_req = tag;
        lkp_addr = a;
        @(negedge clk); #1;
        checks++;
        if (lkp_type !== e) begin
            errors++;
            $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, a, lkp_type, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 11; k++) m_fix[k] = '0;
        for (int i = 0; i < NV; i++) begin m_base[i] = '0; m_mask[i] = '0; end
        lkp_addr = 36'h0009C000;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (lkp_type !== 3'd0) begin
            errors++;
            $display("FAIL R8 reset actual=%0d expected=0", lkp_type);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;
        run = 1'b1;

        // R7: default only
        wr(0, 64'h806, "R8");
        expect_t(36'h123456789, 3'd6, "R7");
        // R1: disabled
        wr(0, 64'h006, "R1");
        expect_t(36'h123456789, 3'd0, "R1");

        // R2: fixed map
        for (int k = 0; k < 11; k++) begin
            logic [63:0] w;
            w = '0;
            for (int j = 0; j < 8; j++) w[8*j +: 8] = 8'((k*3 + j) % 8);
            wr(2 + k, w, "R2");
        end
        wr(1, 64'h100, "R2");
        wr(0, 64'hC01, "R2");
        expect_t(36'h00000, 3'd0, "R2");
        expect_t(36'h10000, 3'd1, "R2");
        expect_t(36'h7FFFF, 3'd7, "R2");
        expect_t(36'h9C000, 3'd2, "R2");
        expect_t(36'hA0000, 3'd6, "R2");
        expect_t(36'hC0000, 3'd1, "R2");
        expect_t(36'hC8000, 3'd4, "R2");
        expect_t(36'hF8FFF, 3'd6, "R2");
        expect_t(36'hFF000, 3'd5, "R2");
        expect_t(36'hFFFFF, 3'd5, "R2");
        expect_t(36'h100000, 3'd1, "R7");
        // R1 again with fixed configured
        wr(0, 64'h401, "R1");
        expect_t(36'h9C000, 3'd0, "R1");

        // R3: gating
        wr(0, 64'h801, "R3");
        expect_t(36'h9C000, 3'd1, "R3");
        wr(1, 64'h000, "R3");
        wr(0, 64'hC01, "R3");
        expect_t(36'h9C000, 3'd1, "R3");

        // R4/R5: nested variable ranges ending at 0x7FFFFF
        wr(1, 64'h104, "R6");
        wr(32, 64'h400006, "R4");   wr(33, 64'hFFFC00800, "R4");
        wr(34, 64'h600005, "R5");   wr(35, 64'hFFFE00800, "R5");
        wr(36, 64'h700004, "R5");   wr(37, 64'hFFFF00800, "R5");
        wr(38, 64'h780000, "R5");   wr(39, 64'hFFFF80800, "R5");
        expect_t(36'h500000, 3'd6, "R4");
        expect_t(36'h900000, 3'd1, "R7");
        expect_t(36'h650000, 3'd5, "R5");
        expect_t(36'h710000, 3'd4, "R5");
        expect_t(36'h790000, 3'd0, "R5");
        wr(39, 64'hFFFF80000, "R4");
        expect_t(36'h790000, 3'd4, "R4");
        wr(38, 64'h780FF0, "R4");   wr(39, 64'hFFFF80FFF, "R4");
        expect_t(36'h790000, 3'd0, "R4");
        expect_t(36'h7FFFFF, 3'd0, "R4");

        // R6: count field
        wr(1, 64'h102, "R6");
        expect_t(36'h790000, 3'd5, "R6");
        wr(46, 64'h900000, "R6");   wr(47, 64'hFFFF00800, "R6");
        wr(1, 64'h107, "R6");
        expect_t(36'h900000, 3'd1, "R6");
        wr(1, 64'h108, "R6");
        expect_t(36'h900000, 3'd0, "R6");
        wr(1, 64'h1FF, "R6");
        expect_t(36'h900000, 3'd0, "R6");
        expect_t(36'h790000, 3'd0, "R6");

        // R7: fixed over variable
        wr(46, 64'h000000, "R7");
        expect_t(36'h9C000, 3'd2, "R7");
        wr(0, 64'h801, "R7");
        expect_t(36'h9C000, 3'd0, "R7");

        // R8: unmapped indexes ignored
        wr(20, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        wr(31, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        wr(63, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        expect_t(36'h9C000, 3'd0, "R8");
        expect_t(36'h900000, 3'd1, "R8");
        wr(0, 64'hC01, "R8");
        expect_t(36'h9C000, 3'd2, "R8");

        run = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule